// File: doc/BRIEF.md
# Dual-Bank Host Transfer Register File

This block is the register file a host-side serial bus controller uses to queue packet transfers. It keeps two identical transfer descriptors, set A and set B, so that software can write the setup for one transfer while the engine runs the other. An 8-bit processor bus writes and reads the registers. Each set has a control byte, a buffer start address, a buffer length, a token/endpoint byte and a device address. Two offsets of each set have a different meaning for reads and writes: a read returns the packet status or the remaining byte count from the last completed transfer. A write stores setup parameters.

The block has a pointer that names the set the engine runs next. The engine reports the end of a transfer with a one-cycle completion strobe for that set. The block then disarms that set, captures the engine's result bytes, raises that set's done flag and moves the pointer to the other set. Done flags and three external event inputs feed an interrupt status register. Software clears a status bit by writing 1 to it. An interrupt enable mask gates the status bits onto the active-high interrupt request output.

Top module: `dual_xfer_regs`

## Requirements
- R1: After reset every register reads 0, the pointer selects set A (`cur_sel_o`=0) and `irq_o` is low.
- R2: Set A is at addresses 0h–4h and set B at 8h–Ch with the same layout. Offset 0 is the control byte, offset 1 the buffer start and offset 2 the buffer length. Offsets 0, 1 and 2 read back the value last written.
- R3: A write to offset 3 stores the token code in bits 7:4 and the endpoint in bits 3:0, shown on `cur_pid_ep_o` when that set is current. A read of offset 3 returns the packet status captured at the last accepted completion of that set (0 before any completion).
- R4: A write to offset 4 stores a 7-bit device address, and `cur_dev_o` bit 7 is always 0. A read of offset 4 returns the remaining count captured at the last accepted completion (0 before any).
- R5: Writing a control byte with bit 0 = 1 arms that set. Control bit 0 reads back 1 while the set is armed.
- R6: A completion strobe for an armed set does four things. It clears control bit 0. It captures `pkt_stat_i` and `xfer_cnt_i`. It sets interrupt status bit 0 (set A) or bit 1 (set B). It moves `cur_sel_o` to the other set. All four are visible on the next cycle.
- R7: A completion strobe for a set that is not armed is ignored. The captured bytes, the status register and the pointer stay unchanged.
- R8: The interrupt enable register is at 6h. Bits 0, 1, 4, 5 and 6 are writable. Bits 2, 3 and 7 always read 0.
- R9: The interrupt status register is at Dh. Bit 4 is set by `sof_evt_i`, bit 5 by `attach_evt_i` and bit 6 by `detect_evt_i`. Writing 1 to a bit clears it. An event in the same cycle as the clear wins.
- R10: `irq_o` is high exactly when some status bit and its enable bit are both 1. It follows the cycle after the status or enable change.
- R11: `cur_pre_o` is high when the current set is armed and its control bit 7 (low-speed preamble) is 1.
- R12: Addresses 5h, 7h, Eh and Fh read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| done_a_i | input | 1 | Completion strobe for set A |
| done_b_i | input | 1 | Completion strobe for set B |
| pkt_stat_i | input | 8 | Packet status from the engine, captured on completion |
| xfer_cnt_i | input | 8 | Remaining count from the engine, captured on completion |
| sof_evt_i | input | 1 | Frame timer event |
| attach_evt_i | input | 1 | Device inserted/removed event |
| detect_evt_i | input | 1 | Device detect/resume event |
| irq_o | output | 1 | Active-high interrupt request |
| cur_sel_o | output | 1 | Set the engine runs next (0 = A, 1 = B) |
| cur_ctrl_o | output | 8 | Control byte of the current set |
| cur_pre_o | output | 1 | Preamble request of the current set |
| cur_base_o | output | 8 | Buffer start of the current set |
| cur_len_o | output | 8 | Buffer length of the current set |
| cur_pid_ep_o | output | 8 | Token/endpoint byte of the current set |
| cur_dev_o | output | 8 | Device address of the current set |

## Verification
The dangerous faults are a lost arm flag and a pointer that fails to toggle after a completion. Either one makes the engine take the wrong descriptor or miss a completion. Both show on `cur_sel_o`, `cur_ctrl_o` and the done bits one cycle after the strobe. The bench sends completion strobes to both armed and unarmed sets and reads status, captures and pointer right after each. A wrong status or enable bit shows on `irq_o` in the next cycle, so the bench checks the interrupt line after each event, clear and enable change. It also checks the same-cycle race between an event and a clear.

// File: rtl/xbr_pkg.sv
// Package: shared widths, register offsets and interrupt bit positions
// for the dual-bank transfer register file.
package xbr_pkg;
    localparam int DW      = 8;
    localparam int OFF_W   = 3;
    localparam int N_BANKS = 2;

    typedef logic [DW-1:0] byte_t;

    // Offsets inside one descriptor set
    localparam logic [OFF_W-1:0] OFF_CTRL = 3'd0;
    localparam logic [OFF_W-1:0] OFF_BASE = 3'd1;
    localparam logic [OFF_W-1:0] OFF_LEN  = 3'd2;
    localparam logic [OFF_W-1:0] OFF_TOK  = 3'd3;
    localparam logic [OFF_W-1:0] OFF_DEV  = 3'd4;

    // Control bits
    localparam int CTRL_ARM = 0;
    localparam int CTRL_PRE = 7;

    // Interrupt bit positions and writable mask
    localparam int IB_DONE_A = 0;
    localparam int IB_DONE_B = 1;
    localparam int IB_SOF    = 4;
    localparam int IB_ATTACH = 5;
    localparam int IB_DETECT = 6;
    localparam byte_t INT_MASK = 8'h73;
endpackage

// File: rtl/xbr_bank.sv
// Module: one transfer descriptor set.
// Holds control, buffer start, length, token/endpoint and device address.
// Captures engine status and remaining count on an accepted completion.
// Assumes wr_en is already decoded for this set and off is within 0..4.
module xbr_bank
    import xbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  byte_t            wdata,
    input  logic             done_i,
    input  byte_t            pkt_stat_i,
    input  byte_t            xfer_cnt_i,
    output byte_t            rdata_o,
    output logic             done_ok_o,
    output byte_t            ctrl_o,
    output byte_t            base_o,
    output byte_t            len_o,
    output byte_t            pid_ep_o,
    output byte_t            dev_o
);
    byte_t ctrl_q, base_q, len_q, tok_q, dev_q, stat_q, cnt_q;
    logic  ctrl_wr;

    assign ctrl_wr   = wr_en && (off == OFF_CTRL);
    assign done_ok_o = done_i && ctrl_q[CTRL_ARM];

    // Control byte: a write loads it, an accepted completion drops the arm bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= wdata;
        else if (done_ok_o)
            ctrl_q[CTRL_ARM] <= 1'b0;
    end

    // Setup parameters written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            tok_q  <= '0;
            dev_q  <= '0;
        end else if (wr_en) begin
            case (off)
                OFF_BASE: base_q <= wdata;
                OFF_LEN:  len_q  <= wdata;
                OFF_TOK:  tok_q  <= wdata;
                OFF_DEV:  dev_q  <= {1'b0, wdata[DW-2:0]};
                default:  ;
            endcase
        end
    end

    // Result capture at the moment of an accepted completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            cnt_q  <= '0;
        end else if (done_ok_o) begin
            stat_q <= pkt_stat_i;
            cnt_q  <= xfer_cnt_i;
        end
    end

    // Read mux: offsets 3 and 4 return results, not setup
    always_comb begin
        case (off)
            OFF_CTRL: rdata_o = ctrl_q;
            OFF_BASE: rdata_o = base_q;
            OFF_LEN:  rdata_o = len_q;
            OFF_TOK:  rdata_o = stat_q;
            OFF_DEV:  rdata_o = cnt_q;
            default:  rdata_o = '0;
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign base_o   = base_q;
    assign len_o    = len_q;
    assign pid_ep_o = tok_q;
    assign dev_o    = dev_q;

    // R7: a strobe on an unarmed set leaves the captured results untouched
    a_r7_unarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ctrl_q[CTRL_ARM]) |=> ($stable(stat_q) && $stable(cnt_q)));

    // R6: an accepted completion without a control write disarms the set
    a_r6_disarm_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ctrl_q[CTRL_ARM] && !ctrl_wr) |=> !ctrl_q[CTRL_ARM]);

    // R6: an accepted completion captures the engine status
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ctrl_q[CTRL_ARM]) |=> (stat_q == $past(pkt_stat_i)));
endmodule

// File: rtl/xbr_irq.sv
// Module: interrupt enable and status registers with write-1-to-clear.
// Assumes src_i holds one-cycle event pulses and that reserved bits
// are masked by INT_MASK. A set event wins over a clear in the same cycle.
module xbr_irq
    import xbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_wr,
    input  logic  clr_wr,
    input  byte_t wdata,
    input  byte_t src_i,
    output byte_t en_o,
    output byte_t stat_o,
    output logic  irq_o
);
    byte_t en_q, stat_q, clr_bits;

    assign clr_bits = clr_wr ? wdata : '0;

    // Enable mask register; reserved positions stay zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_wr)
            en_q <= wdata & INT_MASK;
    end

    // Status register: sticky set from sources, cleared by writing ones
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= ((stat_q & ~clr_bits) | src_i) & INT_MASK;
    end

    assign en_o   = en_q;
    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & en_q);

    // R10: an enabled event raises the request on the next cycle
    a_r10_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(src_i & en_q)) && !en_wr) |=> irq_o);

    // R9: a cleared bit with no competing event reads zero afterwards
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((stat_q & $past(wdata & ~src_i)) == '0));

    // R9: an event wins over a same-cycle clear
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[IB_SOF]) |=> stat_q[IB_SOF]);
endmodule

// File: rtl/dual_xfer_regs.sv
// Module: top of the dual-bank host transfer register file.
// Decodes the 4-bit register bus onto two descriptor sets and the
// interrupt block. It also keeps the pointer to the set the engine runs
// next. Assumes one bus write per strobe and one-cycle completion strobes.
module dual_xfer_regs
    import xbr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              done_a_i,
    input  logic              done_b_i,
    input  logic [7:0]        pkt_stat_i,
    input  logic [7:0]        xfer_cnt_i,
    input  logic              sof_evt_i,
    input  logic              attach_evt_i,
    input  logic              detect_evt_i,
    output logic              irq_o,
    output logic              cur_sel_o,
    output logic [7:0]        cur_ctrl_o,
    output logic              cur_pre_o,
    output logic [7:0]        cur_base_o,
    output logic [7:0]        cur_len_o,
    output logic [7:0]        cur_pid_ep_o,
    output logic [7:0]        cur_dev_o
);
    localparam logic [ADDR_W-1:0] ADDR_IEN  = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] ADDR_ISTS = ADDR_W'(13);
    localparam logic [OFF_W-1:0]  OFF_LAST  = OFF_DEV;

    logic             bank_sel;
    logic [OFF_W-1:0] off;
    logic             off_ok;
    logic [N_BANKS-1:0] bank_wr, done_in, done_ok;
    byte_t bank_rd [N_BANKS];
    byte_t ctrl_v  [N_BANKS];
    byte_t base_v  [N_BANKS];
    byte_t len_v   [N_BANKS];
    byte_t tok_v   [N_BANKS];
    byte_t dev_v   [N_BANKS];
    byte_t en_v, stat_v, src_v;
    logic  cur_q;

    assign bank_sel = bus_addr[ADDR_W-1];
    assign off      = bus_addr[OFF_W-1:0];
    assign off_ok   = (off <= OFF_LAST);
    assign done_in  = {done_b_i, done_a_i};

    // One descriptor set per bank, selected by the top address bit
    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        assign bank_wr[g] = bus_wr && off_ok && (bank_sel == g[0]);
        xbr_bank u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (bank_wr[g]),
            .off        (off),
            .wdata      (bus_wdata),
            .done_i     (done_in[g]),
            .pkt_stat_i (pkt_stat_i),
            .xfer_cnt_i (xfer_cnt_i),
            .rdata_o    (bank_rd[g]),
            .done_ok_o  (done_ok[g]),
            .ctrl_o     (ctrl_v[g]),
            .base_o     (base_v[g]),
            .len_o      (len_v[g]),
            .pid_ep_o   (tok_v[g]),
            .dev_o      (dev_v[g])
        );
    end

    // Interrupt sources gathered into their bit positions
    always_comb begin
        src_v            = '0;
        src_v[IB_DONE_A] = done_ok[0];
        src_v[IB_DONE_B] = done_ok[1];
        src_v[IB_SOF]    = sof_evt_i;
        src_v[IB_ATTACH] = attach_evt_i;
        src_v[IB_DETECT] = detect_evt_i;
    end

    xbr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (bus_wr && (bus_addr == ADDR_IEN)),
        .clr_wr (bus_wr && (bus_addr == ADDR_ISTS)),
        .wdata  (bus_wdata),
        .src_i  (src_v),
        .en_o   (en_v),
        .stat_o (stat_v),
        .irq_o  (irq_o)
    );

    // Next-set pointer: moves to the other set after an accepted completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= 1'b0;
        else if (done_ok[0] && !done_ok[1])
            cur_q <= 1'b1;
        else if (done_ok[1] && !done_ok[0])
            cur_q <= 1'b0;
    end

    // Bus read mux across sets, interrupt registers and unmapped holes
    always_comb begin
        if (off_ok)
            bus_rdata = bank_rd[bank_sel];
        else if (bus_addr == ADDR_IEN)
            bus_rdata = en_v;
        else if (bus_addr == ADDR_ISTS)
            bus_rdata = stat_v;
        else
            bus_rdata = '0;
    end

    assign cur_sel_o    = cur_q;
    assign cur_ctrl_o   = ctrl_v[cur_q];
    assign cur_pre_o    = ctrl_v[cur_q][CTRL_ARM] && ctrl_v[cur_q][CTRL_PRE];
    assign cur_base_o   = base_v[cur_q];
    assign cur_len_o    = len_v[cur_q];
    assign cur_pid_ep_o = tok_v[cur_q];
    assign cur_dev_o    = dev_v[cur_q];

    // R6: completing set A alone hands the next transfer to set B
    a_r6_ptr_to_b: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok[0] && !done_ok[1]) |=> cur_sel_o);

    // R6: completing set B alone hands the next transfer to set A
    a_r6_ptr_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok[1] && !done_ok[0]) |=> !cur_sel_o);

    // R7: with no accepted completion the pointer holds
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok == '0) |=> $stable(cur_sel_o));

    // R4: the device address never shows bit 7 set
    a_r4_dev_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |=> !cur_dev_o[7]);
endmodule

// File: tb/dual_xfer_regs_bench.sv
// Bench: a scoreboard. Read tasks queue the expected byte and a
// negedge monitor pops and compares. Port checks are made at negedges.
module dual_xfer_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       done_a_i = 1'b0, done_b_i = 1'b0;
    logic [7:0] pkt_stat_i = '0, xfer_cnt_i = '0;
    logic       sof_evt_i = 1'b0, attach_evt_i = 1'b0, detect_evt_i = 1'b0;
    logic       irq_o, cur_sel_o, cur_pre_o;
    logic [7:0] cur_ctrl_o, cur_base_o, cur_len_o, cur_pid_ep_o, cur_dev_o;

    int n_chk = 0;
    int n_fail = 0;
    logic probe = 1'b0;
    logic done_flag = 1'b0;

    typedef struct {
        logic [3:0] a;
        logic [7:0] e;
        string      t;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    dual_xfer_regs u_dual_xfer_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done_a_i(done_a_i), .done_b_i(done_b_i),
        .pkt_stat_i(pkt_stat_i), .xfer_cnt_i(xfer_cnt_i),
        .sof_evt_i(sof_evt_i), .attach_evt_i(attach_evt_i),
        .detect_evt_i(detect_evt_i), .irq_o(irq_o), .cur_sel_o(cur_sel_o),
        .cur_ctrl_o(cur_ctrl_o), .cur_pre_o(cur_pre_o),
        .cur_base_o(cur_base_o), .cur_len_o(cur_len_o),
        .cur_pid_ep_o(cur_pid_ep_o), .cur_dev_o(cur_dev_o)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard and compares each read
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (probe) begin
                it = sb.pop_front();
                chk(it.t, bus_rdata, it.e);
            end
        end
    end

    task automatic wr(logic [3:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk) #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [7:0] e, string t);
        item_t it;
        it.a = a; it.e = e; it.t = t;
        sb.push_back(it);
        bus_addr = a; probe = 1'b1;
        @(posedge clk) #1;
        probe = 1'b0;
    endtask

    task automatic port(string req, logic [7:0] act_sel, logic [7:0] exp);
        chk(req, act_sel, exp);
    endtask

    task automatic complete(bit b, logic [7:0] st, logic [7:0] cn);
        pkt_stat_i = st; xfer_cnt_i = cn;
        done_a_i = !b; done_b_i = b;
        @(posedge clk) #1;
        done_a_i = 1'b0; done_b_i = 1'b0;
    endtask

    task automatic events(bit s, bit at, bit dt);
        sof_evt_i = s; attach_evt_i = at; detect_evt_i = dt;
        @(posedge clk) #1;
        sof_evt_i = 1'b0; attach_evt_i = 1'b0; detect_evt_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk) #1;

        // R1: reset state
        for (int i = 0; i < 16; i++) rd(4'(i), 8'h00, "R1 reset readback");
        @(negedge clk);
        port("R1 irq after reset", {7'b0, irq_o}, 8'h00);
        port("R1 pointer after reset", {7'b0, cur_sel_o}, 8'h00);
        @(posedge clk) #1;

        // R2/R3/R4: set A setup
        wr(4'h0, 8'h80); wr(4'h1, 8'h10); wr(4'h2, 8'h40);
        wr(4'h3, 8'h91); wr(4'h4, 8'hFF);
        rd(4'h0, 8'h80, "R2 A ctrl");
        rd(4'h1, 8'h10, "R2 A base");
        rd(4'h2, 8'h40, "R2 A len");
        rd(4'h3, 8'h00, "R3 A status before completion");
        rd(4'h4, 8'h00, "R4 A count before completion");
        @(negedge clk);
        port("R3 A token/endpoint", cur_pid_ep_o, 8'h91);
        port("R4 A device addr bit7 dropped", cur_dev_o, 8'h7F);
        port("R2 A base on engine side", cur_base_o, 8'h10);
        port("R11 preamble idle while unarmed", {7'b0, cur_pre_o}, 8'h00);
        @(posedge clk) #1;

        // R2: set B setup
        wr(4'h8, 8'h02); wr(4'h9, 8'h20); wr(4'hA, 8'h08);
        wr(4'hB, 8'h1A); wr(4'hC, 8'h05);
        rd(4'h8, 8'h02, "R2 B ctrl");
        rd(4'h9, 8'h20, "R2 B base");
        rd(4'hA, 8'h08, "R2 B len");
        rd(4'hB, 8'h00, "R3 B status read differs from write");
        rd(4'hC, 8'h00, "R4 B count read differs from write");

        // R8: enable mask
        wr(4'h6, 8'hFF);
        rd(4'h6, 8'h73, "R8 enable reserved bits");

        // R5/R11: arm A with preamble
        wr(4'h0, 8'h81);
        rd(4'h0, 8'h81, "R5 A armed readback");
        @(negedge clk);
        port("R11 preamble on armed set", {7'b0, cur_pre_o}, 8'h01);
        port("R5 current ctrl armed", cur_ctrl_o, 8'h81);
        @(posedge clk) #1;

        // R7: completion on unarmed set B is ignored
        complete(1'b1, 8'h55, 8'h33);
        rd(4'hB, 8'h00, "R7 B status unchanged");
        rd(4'hC, 8'h00, "R7 B count unchanged");
        rd(4'hD, 8'h00, "R7 no done bit");
        @(negedge clk);
        port("R7 irq stays low", {7'b0, irq_o}, 8'h00);
        port("R7 pointer unchanged", {7'b0, cur_sel_o}, 8'h00);
        @(posedge clk) #1;

        // R6: completion on armed set A
        complete(1'b0, 8'h41, 8'h07);
        @(negedge clk);
        port("R6 pointer to B", {7'b0, cur_sel_o}, 8'h01);
        port("R10 irq on enabled done A", {7'b0, irq_o}, 8'h01);
        port("R6 engine now sees B base", cur_base_o, 8'h20);
        @(posedge clk) #1;
        rd(4'h0, 8'h80, "R6 A disarmed");
        rd(4'h3, 8'h41, "R3 A captured status");
        rd(4'h4, 8'h07, "R4 A captured count");
        rd(4'hD, 8'h01, "R6 done A bit");

        // R9/R10: clear done A
        wr(4'hD, 8'h01);
        rd(4'hD, 8'h00, "R9 write-one clear");
        @(negedge clk);
        port("R10 irq drops after clear", {7'b0, irq_o}, 8'h00);
        @(posedge clk) #1;

        // R6/R10: arm B, mask off, complete B
        wr(4'h8, 8'h03);
        @(negedge clk);
        port("R11 no preamble on B", {7'b0, cur_pre_o}, 8'h00);
        @(posedge clk) #1;
        wr(4'h6, 8'h00);
        complete(1'b1, 8'h12, 8'h00);
        rd(4'hD, 8'h02, "R6 done B bit");
        rd(4'hB, 8'h12, "R3 B captured status");
        rd(4'h8, 8'h02, "R6 B disarmed");
        @(negedge clk);
        port("R10 masked irq low", {7'b0, irq_o}, 8'h00);
        port("R6 pointer back to A", {7'b0, cur_sel_o}, 8'h00);
        @(posedge clk) #1;
        wr(4'hD, 8'h02);

        // R9: event sources
        events(1'b1, 1'b1, 1'b1);
        rd(4'hD, 8'h70, "R9 event bits");
        wr(4'h6, 8'h10);
        @(negedge clk);
        port("R10 irq from enabled frame event", {7'b0, irq_o}, 8'h01);
        @(posedge clk) #1;
        // clear bit 4 while a new frame event arrives: event wins
        bus_addr = 4'hD; bus_wdata = 8'h10; bus_wr = 1'b1; sof_evt_i = 1'b1;
        @(posedge clk) #1;
        bus_wr = 1'b0; sof_evt_i = 1'b0;
        rd(4'hD, 8'h70, "R9 event wins over clear");
        wr(4'hD, 8'h70);
        rd(4'hD, 8'h00, "R9 all cleared");

        // R12: unmapped addresses
        wr(4'h5, 8'hAA); wr(4'h7, 8'h55); wr(4'hE, 8'hFF); wr(4'hF, 8'hFF);
        rd(4'h5, 8'h00, "R12 hole 5");
        rd(4'h7, 8'h00, "R12 hole 7");
        rd(4'hE, 8'h00, "R12 hole E");
        rd(4'hF, 8'h00, "R12 hole F");
        rd(4'h6, 8'h10, "R12 enable untouched");
        rd(4'h1, 8'h10, "R12 A base untouched");

        repeat (2) @(posedge clk);
        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule